// File: doc/BRIEF.md
# Pipelined YCbCr to RGB565 Colour Converter

This block turns a stream of 8-bit luma and chroma samples into packed 16-bit RGB565 pixels, one pixel on every clock. Each pixel passes through four registered stages. The first removes the black-level offset from luma and the mid-scale offset from both chroma components. The second forms constant-coefficient products in fixed point, scaled by 256. The third sums the products for each channel, adds a rounding half-LSB and drops the eight fraction bits. The fourth clamps every channel to 0..255 and packs the upper bits of each into the output word.

The data-enable, horizontal-sync, vertical-sync and field-identifier strobes run through a four-stage delay line beside the data path. They therefore leave in the same cycle as the pixel they came in with. A downstream display or frame-buffer writer can use them without any realignment.

The block sits between a source that has already split its stream into per-pixel Y, Cb and Cr values and a consumer of RGB565 pixels. It has no configuration and no register interface.

Top module: `ycc2rgb565_top`

## Requirements
- R1: Red is round((298·(Y−16) + 409·(Cr−128)) / 256), computed by adding 128 before an arithmetic shift right by 8, and then clamped to 0..255.
- R2: Green is round((298·(Y−16) − 208·(Cr−128) − 100·(Cb−128)) / 256), using the same rounding, and then clamped to 0..255.
- R3: Blue is round((298·(Y−16) + 516·(Cb−128)) / 256), using the same rounding, and then clamped to 0..255.
- R4: A channel value below 0 becomes 0 before packing.
- R5: A channel value above 255 becomes 255 before packing, so its packed field is all ones.
- R6: The output word carries red bits 7:3 in bits 15:11, green bits 7:2 in bits 10:5 and blue bits 7:3 in bits 4:0.
- R7: A pixel presented at a rising clock edge appears on the output word exactly 4 rising edges later. A new pixel is accepted on every edge, with no stalls.
- R8: Data enable, horizontal sync, vertical sync and field identifier are each delayed by exactly the same 4 edges and leave alongside their pixel.
- R9: While reset is held, the output word and all four output strobes are 0. After release they stay 0 until the first pixel accepted after release arrives, 4 edges later.
- R10: Reset is synchronous and active low. Inputs presented while reset is low have no effect on any output, during reset or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_y | input | 8 | Luma sample |
| pix_cb | input | 8 | Blue-difference chroma sample |
| pix_cr | input | 8 | Red-difference chroma sample |
| in_de | input | 1 | Data enable accompanying the sample |
| in_hs | input | 1 | Horizontal sync accompanying the sample |
| in_vs | input | 1 | Vertical sync accompanying the sample |
| in_fld | input | 1 | Field identifier accompanying the sample |
| rgb_out | output | 16 | Packed RGB565 pixel |
| out_de | output | 1 | Data enable, delayed to match rgb_out |
| out_hs | output | 1 | Horizontal sync, delayed to match rgb_out |
| out_vs | output | 1 | Vertical sync, delayed to match rgb_out |
| out_fld | output | 1 | Field identifier, delayed to match rgb_out |

## Verification
Every result of this block is due 4 rising edges after the edge that captured its inputs. This holds for the packed pixel and for each of the four strobes alike. The bench drives a new pixel on every falling edge and pushes the value the equations predict into a queue. At each later falling edge it pops the entry pushed four falling edges earlier and compares it with the outputs, which have just settled after the fourth rising edge. Reset is sampled on the first rising edge after it falls, so the outputs are checked for zero on the very next falling edge. After release the queue is refilled with four zero entries, which covers the stages that reset cleared.

// File: rtl/ycc_pkg.sv
// Package: shared widths, offsets and fixed-point coefficients for the
// YCbCr to RGB565 pipeline. Assumes 8-bit components and a Q8 scale.
package ycc_pkg;
    localparam int PIX_W   = 8;                 // component width
    localparam int FRAC_W  = 8;                 // coefficient fraction bits
    localparam int OFF_W   = PIX_W + 1;         // signed offset-removed width
    localparam int COEF_W  = 11;                // signed width of largest coefficient
    localparam int PROD_W  = OFF_W + COEF_W;    // product width
    localparam int SUM_W   = PROD_W + 2;        // three-term sum width
    localparam int CH_W    = SUM_W - FRAC_W;    // channel width after shift
    localparam int CTRL_W  = 4;                 // {fld, vs, hs, de}
    localparam int LAT     = 4;                 // pipeline depth
    localparam int RED_W   = 5;
    localparam int GRN_W   = 6;
    localparam int BLU_W   = 5;
    localparam int OUT_W   = RED_W + GRN_W + BLU_W;
    localparam int LUMA_OFS   = 1 << (PIX_W - 4);
    localparam int CHROMA_OFS = 1 << (PIX_W - 1);
    localparam int N_PROD  = 5;
    // product order: luma, red<-Cr, green<-Cr, green<-Cb, blue<-Cb
    localparam int COEF [N_PROD] = '{298, 409, 208, 100, 516};
    // operand select: 0 = luma, 1 = Cb, 2 = Cr
    localparam int OPSEL [N_PROD] = '{0, 2, 2, 1, 1};
endpackage

// File: rtl/ycc_offset.sv
// Stage 1: removes the luma black level and the chroma mid-scale offset.
// Assumes unsigned inputs; outputs are signed and one bit wider.
module ycc_offset
    import ycc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PIX_W-1:0]        y_in,
    input  logic [PIX_W-1:0]        cb_in,
    input  logic [PIX_W-1:0]        cr_in,
    output logic signed [OFF_W-1:0] y_o,
    output logic signed [OFF_W-1:0] cb_o,
    output logic signed [OFF_W-1:0] cr_o
);
    localparam logic signed [OFF_W-1:0] Y_OFS = OFF_W'(LUMA_OFS);
    localparam logic signed [OFF_W-1:0] C_OFS = OFF_W'(CHROMA_OFS);

    // register the offset-removed components
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o  <= '0;
            cb_o <= '0;
            cr_o <= '0;
        end else begin
            y_o  <= $signed({1'b0, y_in})  - Y_OFS;
            cb_o <= $signed({1'b0, cb_in}) - C_OFS;
            cr_o <= $signed({1'b0, cr_in}) - C_OFS;
        end
    end

    AST_LUMA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (y_o == $signed({1'b0, $past(y_in)}) - Y_OFS)); // R1
endmodule

// File: rtl/ycc_mult.sv
// Stage 2: forms the five constant-coefficient products in Q8 fixed point.
// Assumes signed offset-removed operands; one generate branch per product.
module ycc_mult
    import ycc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [OFF_W-1:0]  y_i,
    input  logic signed [OFF_W-1:0]  cb_i,
    input  logic signed [OFF_W-1:0]  cr_i,
    output logic signed [PROD_W-1:0] prod [N_PROD]
);
    for (genvar i = 0; i < N_PROD; i++) begin : g_prod
        logic signed [PROD_W-1:0] op;
        localparam logic signed [PROD_W-1:0] K = PROD_W'(COEF[i]);

        // pick this product's operand
        always_comb begin
            if (OPSEL[i] == 0)      op = PROD_W'(y_i);
            else if (OPSEL[i] == 1) op = PROD_W'(cb_i);
            else                    op = PROD_W'(cr_i);
        end

        // register the product
        always_ff @(posedge clk) begin
            if (!rst_n) prod[i] <= '0;
            else        prod[i] <= op * K;
        end
    end
endmodule

// File: rtl/ycc_sum.sv
// Stage 3: combines products per channel, rounds by half an LSB and drops
// the fraction bits with an arithmetic shift. Result is signed, unclamped.
module ycc_sum
    import ycc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [PROD_W-1:0] prod [N_PROD],
    output logic signed [CH_W-1:0]   r_o,
    output logic signed [CH_W-1:0]   g_o,
    output logic signed [CH_W-1:0]   b_o
);
    localparam logic signed [SUM_W-1:0] RND = SUM_W'(1 << (FRAC_W - 1));
    logic signed [SUM_W-1:0] r_full, g_full, b_full;

    // full-width channel sums with rounding constant
    always_comb begin
        r_full = SUM_W'(prod[0]) + SUM_W'(prod[1]) + RND;
        g_full = SUM_W'(prod[0]) - SUM_W'(prod[2]) - SUM_W'(prod[3]) + RND;
        b_full = SUM_W'(prod[0]) + SUM_W'(prod[4]) + RND;
    end

    // register the integer part of each sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_o <= '0;
            g_o <= '0;
            b_o <= '0;
        end else begin
            r_o <= r_full[SUM_W-1:FRAC_W];
            g_o <= g_full[SUM_W-1:FRAC_W];
            b_o <= b_full[SUM_W-1:FRAC_W];
        end
    end
endmodule

// File: rtl/ycc_clip_pack.sv
// Stage 4: clamps each channel to the unsigned component range and packs the
// upper bits into an RGB565 word (red high, blue low).
module ycc_clip_pack
    import ycc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [CH_W-1:0] r_i,
    input  logic signed [CH_W-1:0] g_i,
    input  logic signed [CH_W-1:0] b_i,
    output logic [OUT_W-1:0]       rgb_o
);
    localparam logic signed [CH_W-1:0] MAXV = CH_W'((1 << PIX_W) - 1);

    function automatic logic [PIX_W-1:0] clamp(input logic signed [CH_W-1:0] v);
        if (v < 0)         return '0;
        else if (v > MAXV) return '1;
        else               return v[PIX_W-1:0];
    endfunction

    logic [PIX_W-1:0] r_c, g_c, b_c;

    // clamp all three channels
    always_comb begin
        r_c = clamp(r_i);
        g_c = clamp(g_i);
        b_c = clamp(b_i);
    end

    // register the packed word
    always_ff @(posedge clk) begin
        if (!rst_n) rgb_o <= '0;
        else        rgb_o <= {r_c[PIX_W-1 -: RED_W], g_c[PIX_W-1 -: GRN_W], b_c[PIX_W-1 -: BLU_W]};
    end

    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (b_i < 0) |=> (rgb_o[BLU_W-1:0] == '0)); // R4
    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_i > MAXV) |=> (rgb_o[OUT_W-1 -: RED_W] == '1)); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (rgb_o == '0)); // R9
endmodule

// File: rtl/ycc_ctrl_delay.sv
// Delay line for the video strobes; depth equals the data path latency so
// strobes leave with their pixel. Assumes synchronous active-low reset.
module ycc_ctrl_delay #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] sh [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        // shift one tap per clock
        always_ff @(posedge clk) begin
            if (!rst_n)      sh[i] <= '0;
            else if (i == 0) sh[i] <= d;
            else             sh[i] <= sh[(i == 0) ? 0 : i - 1];
        end
    end

    assign q = sh[DEPTH-1];

    AST_CTRL_RESET: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R9
endmodule

// File: rtl/ycc2rgb565_top.sv
// Top: four-stage YCbCr to RGB565 converter with matched strobe delay.
// Assumes one pixel per clock and synchronous active-low reset.
module ycc2rgb565_top
    import ycc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_y,
    input  logic [PIX_W-1:0]  pix_cb,
    input  logic [PIX_W-1:0]  pix_cr,
    input  logic              in_de,
    input  logic              in_hs,
    input  logic              in_vs,
    input  logic              in_fld,
    output logic [OUT_W-1:0]  rgb_out,
    output logic              out_de,
    output logic              out_hs,
    output logic              out_vs,
    output logic              out_fld
);
    logic signed [OFF_W-1:0]  y_s1, cb_s1, cr_s1;
    logic signed [PROD_W-1:0] prod_s2 [N_PROD];
    logic signed [CH_W-1:0]   r_s3, g_s3, b_s3;
    logic [CTRL_W-1:0]        ctl_in, ctl_out;

    ycc_offset u_ofs (
        .clk(clk), .rst_n(rst_n), .y_in(pix_y), .cb_in(pix_cb), .cr_in(pix_cr),
        .y_o(y_s1), .cb_o(cb_s1), .cr_o(cr_s1)
    );

    ycc_mult u_mul (
        .clk(clk), .rst_n(rst_n), .y_i(y_s1), .cb_i(cb_s1), .cr_i(cr_s1),
        .prod(prod_s2)
    );

    ycc_sum u_sum (
        .clk(clk), .rst_n(rst_n), .prod(prod_s2),
        .r_o(r_s3), .g_o(g_s3), .b_o(b_s3)
    );

    ycc_clip_pack u_pack (
        .clk(clk), .rst_n(rst_n), .r_i(r_s3), .g_i(g_s3), .b_i(b_s3),
        .rgb_o(rgb_out)
    );

    assign ctl_in = {in_fld, in_vs, in_hs, in_de};

    ycc_ctrl_delay #(.W(CTRL_W), .DEPTH(LAT)) u_dly (
        .clk(clk), .rst_n(rst_n), .d(ctl_in), .q(ctl_out)
    );

    assign {out_fld, out_vs, out_hs, out_de} = ctl_out;

    // cycles since reset release, saturating at the latency (assertion use)
    logic [2:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_cnt <= '0;
        else if (run_cnt != 3'(LAT)) run_cnt <= run_cnt + 3'd1;
    end

    AST_CTRL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 3'(LAT)) |-> (ctl_out == $past(ctl_in, 4))); // R8
    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt < 3'(LAT)) |-> (ctl_out == '0 && rgb_out == '0)); // R9
endmodule

// File: tb/sim_ycc2rgb565_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference with a queue of predicted results, compared
// on every falling edge four pixels after each stimulus.
module sim_ycc2rgb565_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] pix_y = '0, pix_cb = '0, pix_cr = '0;
    logic in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0, in_fld = 1'b0;
    logic [15:0] rgb_out;
    logic out_de, out_hs, out_vs, out_fld;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int r_raw, g_raw, b_raw;
        logic [15:0] word;
        logic [3:0]  ctl;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    ycc2rgb565_top u0 (
        .clk(clk), .rst_n(rst_n), .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs), .in_fld(in_fld),
        .rgb_out(rgb_out), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
        .out_fld(out_fld)
    );

    function automatic int clampi(int v);
        return (v < 0) ? 0 : (v > 255) ? 255 : v;
    endfunction

    function automatic exp_t model(int y, int cb, int cr, logic [3:0] c);
        exp_t e;
        int ry, rc, rb;
        e.r_raw = (298*(y-16) + 409*(cr-128) + 128) >>> 8;
        e.g_raw = (298*(y-16) - 208*(cr-128) - 100*(cb-128) + 128) >>> 8;
        e.b_raw = (298*(y-16) + 516*(cb-128) + 128) >>> 8;
        ry = clampi(e.r_raw); rc = clampi(e.g_raw); rb = clampi(e.b_raw);
        e.word = {5'(ry >> 3), 6'(rc >> 2), 5'(rb >> 3)};
        e.ctl = c;
        return e;
    endfunction

    function automatic exp_t zero_exp();
        exp_t e;
        e.r_raw = 0; e.g_raw = 0; e.b_raw = 0; e.word = '0; e.ctl = '0;
        return e;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic string tag(int raw, string base);
        return (raw < 0) ? "R4" : (raw > 255) ? "R5" : base;
    endfunction

    // compare outputs with the entry pushed four falling edges ago
    task automatic compare_out();
        exp_t e;
        e = q.pop_front();
        chk(tag(e.r_raw, "R1"), 32'(rgb_out[15:11]), 32'(e.word[15:11]));
        chk(tag(e.g_raw, "R2"), 32'(rgb_out[10:5]),  32'(e.word[10:5]));
        chk(tag(e.b_raw, "R3"), 32'(rgb_out[4:0]),   32'(e.word[4:0]));
        chk("R6/R7 word", 32'(rgb_out), 32'(e.word));
        chk("R8 strobes", 32'({out_fld, out_vs, out_hs, out_de}), 32'(e.ctl));
    endtask

    task automatic drive(int y, int cb, int cr, logic [3:0] c);
        pix_y = 8'(y); pix_cb = 8'(cb); pix_cr = 8'(cr);
        {in_fld, in_vs, in_hs, in_de} = c;
        q.push_back(model(y, cb, cr, c));
    endtask

    task automatic step(int y, int cb, int cr, logic [3:0] c);
        @(negedge clk);
        compare_out();
        drive(y, cb, cr, c);
    endtask

    // hold reset with busy inputs, then release and restart the queue
    task automatic reset_seq(int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        {pix_y, pix_cb, pix_cr} = 24'($urandom);
        {in_fld, in_vs, in_hs, in_de} = 4'hF;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R9/R10 reset word", 32'(rgb_out), 32'h0);
            chk("R9/R10 reset strobes", 32'({out_fld, out_vs, out_hs, out_de}), 32'h0);
            {pix_y, pix_cb, pix_cr} = 24'($urandom);
            {in_fld, in_vs, in_hs, in_de} = 4'($urandom) | 4'h1;
        end
        rst_n = 1'b1;
        q.delete();
        for (int i = 0; i < 4; i++) q.push_back(zero_exp());
        compare_out(); // R10: nothing driven during reset leaks out
        drive(16, 128, 128, 4'h0);
    endtask

    initial begin
        reset_seq(3);
        // named colours
        step(16, 128, 128, 4'h1);   // black
        step(235, 128, 128, 4'h1);  // white
        step(81, 90, 240, 4'h3);    // red
        step(145, 54, 34, 4'h1);    // green
        step(41, 240, 110, 4'h5);   // blue
        step(210, 16, 146, 4'h9);   // yellow
        // clamp corners
        step(255, 255, 255, 4'h1);
        step(0, 0, 0, 4'h2);
        step(0, 255, 0, 4'h4);
        step(255, 0, 255, 4'h8);
        step(128, 0, 255, 4'hF);
        step(128, 255, 0, 4'h0);
        // luma sweep at neutral and saturated chroma
        for (int i = 0; i < 256; i++) step(i, 128, 128, 4'(i));
        for (int i = 0; i < 256; i++) step(i, 255 - i, i, 4'(i >> 2));
        // reset in mid-stream, then random traffic
        reset_seq(4);
        for (int i = 0; i < 1500; i++)
            step(int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(255)), 4'($urandom));
        // drain the pipeline with neutral pixels
        for (int i = 0; i < 4; i++) step(16, 128, 128, 4'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule